// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes up to two SDR SDRAM DIMM sockets from power-up to normal operation. A one-cycle start pulse makes it take a snapshot of the socket configuration. That snapshot holds the presence, size in megabytes and dual-sided flag of each socket, the CAS-latency choice and the refresh-rate choice. The block then steps through the fixed bring-up order. Each step is sent as a 3-bit mode-select code, together with a byte address for every populated socket side. When bring-up is finished, the block enters normal mode, raises `done_o` and produces a periodic refresh request strobe.

The core is a single state machine with these states:
- `ST_IDLE`: the reset state, with the NOP code on the output.
- `ST_NOP_ISSUE`, `ST_PRE_ISSUE`, `ST_REF_ISSUE`, `ST_MRS_ISSUE`: each issue state lasts four cycles, one per target slot.
- `ST_PRE_WAIT`, `ST_REF_WAIT`, `ST_MRS_WAIT`: each wait state counts a parameterised interval.
- `ST_NORM_ENTER`: lasts one cycle.
- `ST_RUN`: normal mode with periodic refresh.

The transitions are:
- start: from `ST_IDLE` or `ST_RUN` to `ST_NOP_ISSUE`.
- slot-sweep-end: after the fourth slot, the machine moves from each issue state to the state that follows it.
- interval-end: `ST_PRE_WAIT` goes to `ST_REF_ISSUE`. `ST_MRS_WAIT` goes to `ST_NORM_ENTER`. `ST_REF_WAIT` goes back to `ST_REF_ISSUE` until the last refresh, and then to `ST_MRS_ISSUE`.
- handover: from `ST_NORM_ENTER` to `ST_RUN`.

Top module: `sdram_powerup_seq`

## Requirements
- R1: Mode-select codes on `cmd_o` are 4 NOP, 5 precharge-all, 7 auto (CBR) refresh, 6 mode-register set, 1 normal and 2 normal with fast refresh; code 3 never appears. Code 0 (self-refresh) is part of the code set but is never emitted.
- R2: After an accepted start, commands appear in this order: NOP, precharge-all, NUM_CBR (default 8) refresh commands, mode-register set, normal. Within each command, `cmd_valid_o` pulses once for each populated target, in slot order: socket 0 side 0, socket 0 side 1, socket 1 side 0, socket 1 side 1. Side 1 counts only for dual-sided sockets.
- R3: Each issue phase lasts 4 cycles. Precharge-all is followed by T_RP cycles, each refresh by T_RC cycles, and mode-register set by T_MRD cycles. The normal-entry step lasts 1 cycle. `busy_o` is therefore high for 4+4+T_RP+NUM_CBR*(4+T_RC)+4+T_MRD+1 cycles.
- R4: Normal mode (code 1 or 2) never comes with a `cmd_valid_o` pulse.
- R5: The target address is (base_MB + side_MB) << 20, plus an offset. Socket 0 has base 0. Socket 1 has as its base the size of socket 0, or 0 if socket 0 is empty. The side-1 target adds half of the socket's size.
- R6: The mode-register-set offset is a 13-bit pattern shifted left by 3. The pattern is 0x2A, with bit 4 set for CAS latency 3 (`cas3_i`=1). For socket 1, pattern bits [7:4] are inverted. This gives 0x1D0/0x150 for socket 0 and 0x650/0x6D0 for socket 1 at CL3/CL2. All other commands use offset 0.
- R7: `done_o` rises one cycle after `cmd_o` shows the normal code, and is never high together with `busy_o`.
- R8: In `ST_RUN`, `refresh_o` pulses for one cycle every REF_CYC cycles, or every REF_CYC/2 cycles when fast refresh was selected (code 2). The first pulse comes in the REF_CYC-th (or REF_CYC/2-th) cycle with `done_o` high.
- R9: A start pulse while `busy_o` is high is ignored. Input changes after an accepted start do not affect the running sequence. A start while `done_o` is high re-runs the whole sequence.
- R10: Reset, including reset in the middle of a sequence, returns the block to idle with `cmd_o`=4 and `busy_o`, `done_o`, `cmd_valid_o` and `refresh_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| cas3_i | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| fast_ref_i | input | 1 | Select fast-refresh normal mode |
| present_i | input | 2 | Socket populated flags |
| dual_i | input | 2 | Socket dual-sided flags |
| sock0_mb_i | input | SZW | Socket 0 size in MB |
| sock1_mb_i | input | SZW | Socket 1 size in MB |
| cmd_o | output | 3 | Mode-select code |
| cmd_valid_o | output | 1 | Command sent to the target on `addr_o` this cycle |
| addr_o | output | AW | Target byte address |
| busy_o | output | 1 | Initialization in progress |
| done_o | output | 1 | Normal mode reached |
| refresh_o | output | 1 | Periodic refresh request strobe |

## Verification
The bench sets up several socket configurations and compares the full logged stream of commands and addresses against a list it builds itself. The configurations cover:
- an empty first socket, which exposes a design that does not collapse socket 1's base to zero;
- dual-sided sockets, which expose a missing or misplaced side-1 target;
- socket 1 mode-register sets at both CAS latencies, which expose a missed bit inversion or a wrong CAS bit.

The busy length catches a design that skips or adds a refresh, or miscounts any wait. The gap between refresh pulses catches a design that ignores the fast-refresh choice. A start pulse and changed inputs injected mid-sequence show whether the design restarts early or picks up the new configuration. A reset mid-sequence shows whether any busy state survives reset.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [2:0] {
        MS_SELF_REF    = 3'd0,
        MS_NORMAL      = 3'd1,
        MS_NORMAL_FAST = 3'd2,
        MS_NOP         = 3'd4,
        MS_PRECHARGE   = 3'd5,
        MS_MODE_SET    = 3'd6,
        MS_AUTO_REF    = 3'd7
    } mode_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NOP_ISSUE,
        ST_PRE_ISSUE,
        ST_PRE_WAIT,
        ST_REF_ISSUE,
        ST_REF_WAIT,
        ST_MRS_ISSUE,
        ST_MRS_WAIT,
        ST_NORM_ENTER,
        ST_RUN
    } seq_state_e;

    localparam int unsigned SOCKETS   = 2;
    localparam int unsigned SLOT_BITS = 2;
    localparam logic [12:0] MRS_PATTERN = 13'h002A;
    localparam logic [12:0] MRS_SOCK1_FLIP = 13'h00F0;
    localparam logic [12:0] MRS_CL3_BIT = 13'h0010;

endpackage

// File: rtl/sdinit_fsm.sv
module sdinit_fsm
    import sdinit_pkg::*;
#(
    parameter int unsigned T_RP    = 2,
    parameter int unsigned T_RC    = 7,
    parameter int unsigned T_MRD   = 2,
    parameter int unsigned NUM_CBR = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 fast_i,
    output logic                 accept_o,
    output logic                 issue_o,
    output logic                 is_mrs_o,
    output logic [SLOT_BITS-1:0] slot_o,
    output logic [2:0]           cmd_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 run_o,
    output logic                 fast_q_o
);

    localparam int unsigned WAIT_MAX = (T_RP > T_RC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                                     : ((T_RC > T_MRD) ? T_RC : T_MRD);
    localparam int unsigned WW = $clog2(WAIT_MAX + 1);
    localparam int unsigned CW = $clog2(NUM_CBR + 1);
    localparam logic [SLOT_BITS-1:0] LAST_SLOT = '1;

    seq_state_e           state, state_n;
    logic [SLOT_BITS-1:0] slot;
    logic [WW-1:0]        wait_cnt;
    logic [CW-1:0]        cbr_cnt;
    logic                 fast_q;
    logic                 accept;
    logic                 slot_end;
    logic                 wait_end;

    assign accept   = start_i && (state == ST_IDLE || state == ST_RUN);
    assign slot_end = (slot == LAST_SLOT);
    assign wait_end = (wait_cnt == '0);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE, ST_RUN: if (start_i) state_n = ST_NOP_ISSUE;
            ST_NOP_ISSUE:    if (slot_end) state_n = ST_PRE_ISSUE;
            ST_PRE_ISSUE:    if (slot_end) state_n = ST_PRE_WAIT;
            ST_PRE_WAIT:     if (wait_end) state_n = ST_REF_ISSUE;
            ST_REF_ISSUE:    if (slot_end) state_n = ST_REF_WAIT;
            ST_REF_WAIT: begin
                if (wait_end) begin
                    state_n = (cbr_cnt == CW'(NUM_CBR - 1)) ? ST_MRS_ISSUE : ST_REF_ISSUE;
                end
            end
            ST_MRS_ISSUE:    if (slot_end) state_n = ST_MRS_WAIT;
            ST_MRS_WAIT:     if (wait_end) state_n = ST_NORM_ENTER;
            ST_NORM_ENTER:   state_n = ST_RUN;
            default:         state_n = ST_IDLE;
        endcase
    end

    // State register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            slot     <= '0;
            wait_cnt <= '0;
            cbr_cnt  <= '0;
            fast_q   <= 1'b0;
        end else begin
            state <= state_n;
            if (accept) fast_q <= fast_i;

            if (issue_o) slot <= slot + 1'b1;
            else         slot <= '0;

            if (state_n != state) begin
                unique case (state_n)
                    ST_PRE_WAIT: wait_cnt <= WW'(T_RP - 1);
                    ST_REF_WAIT: wait_cnt <= WW'(T_RC - 1);
                    ST_MRS_WAIT: wait_cnt <= WW'(T_MRD - 1);
                    default:     wait_cnt <= '0;
                endcase
            end else if (!wait_end) begin
                wait_cnt <= wait_cnt - 1'b1;
            end

            if (accept) cbr_cnt <= '0;
            else if (state == ST_REF_WAIT && wait_end) cbr_cnt <= cbr_cnt + 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        cmd_o    = MS_NOP;
        issue_o  = 1'b0;
        is_mrs_o = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        unique case (state)
            ST_IDLE:       busy_o = 1'b0;
            ST_NOP_ISSUE:  begin cmd_o = MS_NOP; issue_o = 1'b1; end
            ST_PRE_ISSUE:  begin cmd_o = MS_PRECHARGE; issue_o = 1'b1; end
            ST_PRE_WAIT:   cmd_o = MS_PRECHARGE;
            ST_REF_ISSUE:  begin cmd_o = MS_AUTO_REF; issue_o = 1'b1; end
            ST_REF_WAIT:   cmd_o = MS_AUTO_REF;
            ST_MRS_ISSUE:  begin cmd_o = MS_MODE_SET; issue_o = 1'b1; is_mrs_o = 1'b1; end
            ST_MRS_WAIT:   cmd_o = MS_MODE_SET;
            ST_NORM_ENTER: cmd_o = fast_q ? MS_NORMAL_FAST : MS_NORMAL;
            ST_RUN: begin
                cmd_o  = fast_q ? MS_NORMAL_FAST : MS_NORMAL;
                busy_o = 1'b0;
                done_o = 1'b1;
            end
            default:       busy_o = 1'b0;
        endcase
    end

    assign accept_o = accept;
    assign slot_o   = slot;
    assign run_o    = (state == ST_RUN);
    assign fast_q_o = fast_q;

endmodule

// File: rtl/sdinit_target.sv
module sdinit_target
    import sdinit_pkg::*;
#(
    parameter int unsigned SZW      = 9,
    parameter int unsigned AW       = 30,
    parameter int unsigned MB_SHIFT = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [SOCKETS-1:0]   present_i,
    input  logic [SOCKETS-1:0]   dual_i,
    input  logic [SZW-1:0]       mb0_i,
    input  logic [SZW-1:0]       mb1_i,
    input  logic                 cas3_i,
    input  logic                 issue_i,
    input  logic                 is_mrs_i,
    input  logic [SLOT_BITS-1:0] slot_i,
    output logic                 valid_o,
    output logic [AW-1:0]        addr_o
);

    logic [SOCKETS-1:0] pres_q, dual_q;
    logic [SZW-1:0]     size_q [SOCKETS];
    logic               cas3_q;
    logic [SZW-1:0]     span [SOCKETS];
    logic [SZW-1:0]     half [SOCKETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pres_q    <= '0;
            dual_q    <= '0;
            size_q[0] <= '0;
            size_q[1] <= '0;
            cas3_q    <= 1'b0;
        end else if (load_i) begin
            pres_q    <= present_i;
            dual_q    <= dual_i;
            size_q[0] <= mb0_i;
            size_q[1] <= mb1_i;
            cas3_q    <= cas3_i;
        end
    end

    // Per-socket occupied span and side-0 size
    for (genvar s = 0; s < SOCKETS; s++) begin : g_sock
        assign span[s] = pres_q[s] ? size_q[s] : '0;
        assign half[s] = size_q[s] >> 1;
    end

    logic           sock, side;
    logic [SZW:0]   mb_sel;
    logic [12:0]    pattern;
    logic [15:0]    offset;
    logic [AW-1:0]  mb_wide;

    assign sock = slot_i[1];
    assign side = slot_i[0];

    always_comb begin
        mb_sel = '0;
        if (sock) mb_sel = {1'b0, span[0]};
        if (side) mb_sel = mb_sel + {1'b0, half[sock]};

        pattern = MRS_PATTERN | (cas3_q ? MRS_CL3_BIT : 13'h0);
        if (sock) pattern = pattern ^ MRS_SOCK1_FLIP;
        offset = {pattern, 3'b000};

        mb_wide = AW'(mb_sel);
        addr_o  = (mb_wide << MB_SHIFT) + (is_mrs_i ? AW'(offset) : '0);
        valid_o = issue_i && pres_q[sock] && (!side || dual_q[sock]);
    end

endmodule

// File: rtl/sdinit_refresh.sv
module sdinit_refresh #(
    parameter int unsigned REF_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_i,
    output logic tick_o
);

    localparam int unsigned REF_FAST = (REF_CYC / 2 < 1) ? 1 : REF_CYC / 2;
    localparam int unsigned CW = $clog2(REF_CYC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last   = fast_i ? CW'(REF_FAST - 1) : CW'(REF_CYC - 1);
    assign tick_o = run_i && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run_i || tick_o) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdinit_pkg::*;
#(
    parameter int unsigned SZW      = 9,
    parameter int unsigned AW       = 30,
    parameter int unsigned MB_SHIFT = 20,
    parameter int unsigned T_RP     = 2,
    parameter int unsigned T_RC     = 7,
    parameter int unsigned T_MRD    = 2,
    parameter int unsigned NUM_CBR  = 8,
    parameter int unsigned REF_CYC  = 1560
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           cas3_i,
    input  logic           fast_ref_i,
    input  logic [1:0]     present_i,
    input  logic [1:0]     dual_i,
    input  logic [SZW-1:0] sock0_mb_i,
    input  logic [SZW-1:0] sock1_mb_i,
    output logic [2:0]     cmd_o,
    output logic           cmd_valid_o,
    output logic [AW-1:0]  addr_o,
    output logic           busy_o,
    output logic           done_o,
    output logic           refresh_o
);

    logic                 accept, issue, is_mrs, run, fast_q;
    logic [SLOT_BITS-1:0] slot;

    sdinit_fsm #(
        .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .NUM_CBR(NUM_CBR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_i(fast_ref_i),
        .accept_o(accept), .issue_o(issue), .is_mrs_o(is_mrs), .slot_o(slot),
        .cmd_o(cmd_o), .busy_o(busy_o), .done_o(done_o), .run_o(run),
        .fast_q_o(fast_q)
    );

    sdinit_target #(
        .SZW(SZW), .AW(AW), .MB_SHIFT(MB_SHIFT)
    ) u_tgt (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .present_i(present_i),
        .dual_i(dual_i), .mb0_i(sock0_mb_i), .mb1_i(sock1_mb_i), .cas3_i(cas3_i),
        .issue_i(issue), .is_mrs_i(is_mrs), .slot_i(slot),
        .valid_o(cmd_valid_o), .addr_o(addr_o)
    );

    sdinit_refresh #(
        .REF_CYC(REF_CYC)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .run_i(run), .fast_i(fast_q), .tick_o(refresh_o)
    );

endmodule

// File: rtl/sdinit_checks.sv
module sdinit_checks #(
    parameter int unsigned AW       = 30,
    parameter int unsigned MB_SHIFT = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cmd_o,
    input logic          cmd_valid_o,
    input logic [AW-1:0] addr_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          refresh_o
);

    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o != 3'd3); // R1

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> busy_o); // R2

    AST_NORMAL_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_o != 3'd1 && cmd_o != 3'd2)); // R4

    AST_MRS_ADDR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == 3'd6) |-> (addr_o[2:0] == 3'd0 && addr_o[MB_SHIFT-1:16] == '0)); // R6

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o)); // R7

    AST_DONE_FOLLOWS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(busy_o) && ($past(cmd_o) == 3'd1 || $past(cmd_o) == 3'd2))); // R7

    AST_REFRESH_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |-> done_o); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_o != 3'd1 && cmd_o != 3'd2) |=> busy_o); // R9

endmodule

bind sdram_powerup_seq sdinit_checks #(.AW(AW), .MB_SHIFT(MB_SHIFT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o),
    .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o), .refresh_o(refresh_o)
);

// File: tb/sim_sdram_powerup_seq.sv
module sim_sdram_powerup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int SZW = 9, AW = 30;
    localparam int T_RP = 3, T_RC = 5, T_MRD = 2, NUM_CBR = 8, REF_CYC = 40;
    localparam int BUSY_LEN = 4 + 4 + T_RP + NUM_CBR * (4 + T_RC) + 4 + T_MRD + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, cas3_i = 1'b0, fast_ref_i = 1'b0;
    logic [1:0] present_i = '0, dual_i = '0;
    logic [SZW-1:0] sock0_mb_i = '0, sock1_mb_i = '0;
    logic [2:0] cmd_o;
    logic cmd_valid_o, busy_o, done_o, refresh_o;
    logic [AW-1:0] addr_o;

    int n_chk = 0, n_fail = 0;
    int ev_n = 0, exp_n = 0;
    int ev_cmd [64], ev_addr [64], exp_cmd [64], exp_addr [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_powerup_seq #(
        .SZW(SZW), .AW(AW), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
        .NUM_CBR(NUM_CBR), .REF_CYC(REF_CYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cas3_i(cas3_i),
        .fast_ref_i(fast_ref_i), .present_i(present_i), .dual_i(dual_i),
        .sock0_mb_i(sock0_mb_i), .sock1_mb_i(sock1_mb_i), .cmd_o(cmd_o),
        .cmd_valid_o(cmd_valid_o), .addr_o(addr_o), .busy_o(busy_o),
        .done_o(done_o), .refresh_o(refresh_o)
    );

    always @(negedge clk) begin
        if (cmd_valid_o && ev_n < 64) begin
            ev_cmd[ev_n]  = int'(cmd_o);
            ev_addr[ev_n] = int'(addr_o);
            ev_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected command stream from R2, R5, R6
    task automatic build_exp(input bit [1:0] pres, input bit [1:0] dual, input int mb0, input int mb1, input bit cas3);
        int phase_cmd [NUM_CBR + 3];
        phase_cmd[0] = 4;
        phase_cmd[1] = 5;
        for (int k = 0; k < NUM_CBR; k++) phase_cmd[2 + k] = 7;
        phase_cmd[NUM_CBR + 2] = 6;
        exp_n = 0;
        for (int p = 0; p < NUM_CBR + 3; p++) begin
            for (int t = 0; t < 4; t++) begin
                int s = t / 2;
                int d = t % 2;
                if (pres[s] && (d == 0 || dual[s])) begin
                    int mb = (s == 1 && pres[0]) ? mb0 : 0;
                    int a;
                    if (d == 1) mb += ((s == 1) ? mb1 : mb0) / 2;
                    a = mb * 1048576;
                    if (phase_cmd[p] == 6) begin
                        int pat = 'h2A | (cas3 ? 'h10 : 0);
                        if (s == 1) pat = pat ^ 'hF0;
                        a += pat * 8;
                    end
                    exp_cmd[exp_n]  = phase_cmd[p];
                    exp_addr[exp_n] = a;
                    exp_n++;
                end
            end
        end
    endtask

    task automatic compare_events(input string tag);
        chk(ev_n == exp_n, "R2", {tag, " event count"}, ev_n, exp_n);
        for (int i = 0; i < exp_n && i < ev_n; i++) begin
            chk(ev_cmd[i] == exp_cmd[i], "R2", {tag, " command order"}, ev_cmd[i], exp_cmd[i]);
            chk(ev_addr[i] == exp_addr[i], (exp_cmd[i] == 6) ? "R6" : "R5", {tag, " address"}, ev_addr[i], exp_addr[i]);
        end
    endtask

    // Runs one sequence; optionally injects a start and changed inputs mid-run
    task automatic run_seq(input bit [1:0] pres, input bit [1:0] dual, input int mb0, input int mb1,
                           input bit cas3, input bit fast, input bit poke, input string tag);
        int cnt = 0;
        ev_n = 0;
        build_exp(pres, dual, mb0, mb1, cas3);
        present_i = pres; dual_i = dual; sock0_mb_i = SZW'(mb0); sock1_mb_i = SZW'(mb1);
        cas3_i = cas3; fast_ref_i = fast; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o && cnt < 2000) begin
            cnt++;
            if (poke && cnt == 30) begin
                start_i = 1'b1; present_i = ~pres; cas3_i = ~cas3; fast_ref_i = ~fast;
                sock0_mb_i = 9'd64; sock1_mb_i = 9'd32; dual_i = ~dual;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(cnt == BUSY_LEN, poke ? "R9" : "R3", {tag, " busy length"}, cnt, BUSY_LEN);
        chk(done_o == 1'b1, "R7", {tag, " done after busy"}, int'(done_o), 1);
        chk(int'(cmd_o) == (fast ? 2 : 1), "R1", {tag, " normal code"}, int'(cmd_o), fast ? 2 : 1);
        compare_events(tag);
        check_refresh(fast ? REF_CYC / 2 : REF_CYC, tag);
    endtask

    task automatic check_refresh(input int period, input string tag);
        int k = 1;
        while (!refresh_o && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(k == period, "R8", {tag, " first refresh cycle"}, k, period);
        @(negedge clk);
        k = 1;
        while (!refresh_o && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(k == period, "R8", {tag, " refresh interval"}, k, period);
    endtask

    task automatic check_idle(input string tag);
        chk(cmd_o == 3'd4, "R10", {tag, " cmd NOP"}, int'(cmd_o), 4);
        chk(!busy_o && !done_o, "R10", {tag, " busy/done low"}, int'({busy_o, done_o}), 0);
        chk(!cmd_valid_o && !refresh_o, "R10", {tag, " strobes low"}, int'({cmd_valid_o, refresh_o}), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_idle("in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("after reset");
    endtask

    task automatic t_two_single();
        run_seq(2'b11, 2'b00, 128, 128, 1'b1, 1'b0, 1'b0, "two single CL3");
    endtask

    task automatic t_dual_fast();
        run_seq(2'b11, 2'b11, 256, 128, 1'b0, 1'b1, 1'b0, "dual CL2 fast");
    endtask

    task automatic t_only_second();
        run_seq(2'b10, 2'b00, 0, 64, 1'b1, 1'b0, 1'b0, "socket1 only");
    endtask

    task automatic t_empty();
        run_seq(2'b00, 2'b00, 0, 0, 1'b0, 1'b1, 1'b0, "no sockets");
    endtask

    task automatic t_start_ignored();
        run_seq(2'b01, 2'b01, 128, 0, 1'b0, 1'b0, 1'b1, "start while busy");
    endtask

    task automatic t_reset_mid();
        present_i = 2'b11; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy_o == 1'b1, "R10", "mid-run busy before reset", int'(busy_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("reset mid-run");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("after mid-run reset");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_two_single();
        t_dual_fast();
        t_only_second();
        t_empty();
        t_start_ignored();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule